// File: doc/BRIEF.md
# DES Round Coprocessor

This block is a DES datapath that sits beside a processor pipeline and is driven one operation at a time. Software first loads a 64-bit key and a 64-bit data block, each as a pair of 32-bit operands. It then issues sixteen round operations, one per clock. Each round operation carries a small immediate. One bit of the immediate picks the cipher direction and another picks a key-half rotation of one or two places. Software finally fetches the output block as two 32-bit words.

There is no round counter and no sequencer inside the block. The rotation schedule belongs to the caller, and every round operation does exactly one Feistel round in one clock. The block holds four pieces of state: the two 28-bit key halves and the two 32-bit data halves. It also holds one registered result word. All permutations and substitution boxes are combinational logic between those registers.

For decryption the caller keeps the key exactly as loaded. Each decrypting round takes its subkey from the current key halves and then rotates them right. A full schedule in either direction therefore leaves the key halves where the load put them. The next block can be processed without loading the key again.

Top module: `des_round_copro`

## Requirements
- R1: A synchronous active-high reset clears both key halves, both data halves, `res_valid` and `res_data`. A read of the block straight after reset returns zero. Sixteen encrypting rounds after reset, with no loads, give the ciphertext 8CA64DE9C1B123A7.
- R2: Operation code 0 (load key) takes the key with `op_hi` as bits 63:32 and `op_lo` as bits 31:0. It splits the key into two 28-bit halves through the standard key-selection permutation. Encrypting with the standard schedule then yields standard DES ciphertext.
- R3: Operation code 1 (load block) takes the block with `op_hi` as bits 63:32 and `op_lo` as bits 31:0. It applies the initial permutation, puts the upper half in the left data register and the lower half in the right data register, and leaves the key untouched.
- R4: Operation code 2 with `op_imm[0]`=0 is an encrypting round. Both key halves rotate left by one place (`op_imm[1]`=0) or by two places (`op_imm[1]`=1). The 48-bit subkey is taken from the rotated halves. The new right half is the old left half XOR f(old right half, subkey), and the new left half is the old right half. The round completes in one clock, so a read issued in the next cycle sees it.
- R5: Operation code 2 with `op_imm[0]`=1 is a decrypting round. The subkey is taken from the key halves as they are, and then both halves rotate right by one or two places, picked by `op_imm[1]`. The decryption schedule 1,2,2,2,2,2,2,1,2,2,2,2,2,2,1,1 recovers the plaintext.
- R6: Operation code 3 (read) returns a word of the final permutation of {right half, left half}: the upper 32 bits when `op_imm[0]`=0 and the lower 32 bits when `op_imm[0]`=1. The word appears on `res_data` one clock after the operation is issued, with `res_valid` high for that one cycle. `res_data` holds its value afterwards, and `res_valid` stays low in every cycle that follows anything other than a read.
- R7: A read, and any cycle with `op_valid` low whatever the other inputs, leaves the key and data state unchanged.
- R8: After a full sixteen-round schedule in either direction, the key halves are back at their loaded value. Another block can then be loaded and processed in either direction without reloading the key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_code | input | 2 | 0 load key, 1 load block, 2 round, 3 read |
| op_imm | input | 2 | Round: bit0 decrypt, bit1 rotate by two; read: bit0 selects the lower word |
| op_hi | input | 32 | Upper operand word (bits 63:32 of a key or block) |
| op_lo | input | 32 | Lower operand word (bits 31:0 of a key or block) |
| res_valid | output | 1 | One-cycle pulse marking a read result |
| res_data | output | 32 | Registered read result |

## Verification
The round function is exercised with five published key and plaintext pairs, each chosen to stress a different part of the datapath:
- An all-zero key and block reached only through reset, which shows that reset really clears the state.
- The common textbook key and block, which exercise every table with mixed bits.
- A pair whose ciphertext is all zeros, which catches a wrong final permutation or a wrong word split.
- All ones in key and block.
- A pair whose ciphertext has a single set bit, which makes any bit-order slip stand out.

Each ciphertext is then decrypted with the reverse schedule, so a wrong rotation direction or a subkey taken at the wrong point fails at once. Rounds interleaved with idle cycles, with reads and with loads marked not valid tell hold behaviour apart from update behaviour. Blocks processed back to back without a key reload show whether the schedule leaves the key halves where it found them.

// File: rtl/des_pkg.sv
package des_pkg;

  localparam int WORD_W   = 32;
  localparam int BLK_W    = 2 * WORD_W;
  localparam int KHALF_W  = 28;
  localparam int KSEL_W   = 2 * KHALF_W;
  localparam int SUBKEY_W = 48;
  localparam int N_SBOX   = 8;
  localparam int SB_IN_W  = SUBKEY_W / N_SBOX;
  localparam int SB_OUT_W = WORD_W / N_SBOX;

  typedef enum logic [1:0] {
    OP_LDKEY = 2'd0,
    OP_LDBLK = 2'd1,
    OP_ROUND = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  // Key selection: 56 source positions (1 = key MSB).
  localparam int KSEL_T [56] = '{
    57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
    10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
    14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4};

  // Subkey compression: 48 source positions over {C,D}.
  localparam int SKC_T [48] = '{
    14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
    23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

  // Round-function output shuffle: 32 source positions.
  localparam int SHUF_T [32] = '{
    16,  7, 20, 21, 29, 12, 28, 17,  1, 15, 23, 26,  5, 18, 31, 10,
     2,  8, 24, 14, 32, 27,  3,  9, 19, 13, 30,  6, 22, 11,  4, 25};

  // Substitution boxes, one 256-bit word each: four rows of sixteen nibbles.
  localparam logic [255:0] SBOX_T [8] = '{
    256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
    256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
    256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
    256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
    256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
    256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
    256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
    256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B};

  function automatic logic [KSEL_W-1:0] key_select(input logic [BLK_W-1:0] k);
    logic [KSEL_W-1:0] o;
    for (int i = 0; i < KSEL_W; i++) o[6'(KSEL_W-1-i)] = k[6'(BLK_W-KSEL_T[i])];
    return o;
  endfunction

  function automatic logic [SUBKEY_W-1:0] key_compress(input logic [KSEL_W-1:0] cd);
    logic [SUBKEY_W-1:0] o;
    for (int i = 0; i < SUBKEY_W; i++) o[6'(SUBKEY_W-1-i)] = cd[6'(KSEL_W-SKC_T[i])];
    return o;
  endfunction

  function automatic int ip_src(input int i);
    int row;
    int col;
    row = i / 8;
    col = i % 8;
    return (row < 4) ? (58 + 2 * row - 8 * col) : (57 + 2 * (row - 4) - 8 * col);
  endfunction

  function automatic logic [BLK_W-1:0] ip_perm(input logic [BLK_W-1:0] b);
    logic [BLK_W-1:0] o;
    for (int i = 0; i < BLK_W; i++) o[6'(BLK_W-1-i)] = b[6'(BLK_W-ip_src(i))];
    return o;
  endfunction

  function automatic logic [BLK_W-1:0] fp_perm(input logic [BLK_W-1:0] b);
    logic [BLK_W-1:0] o;
    for (int i = 0; i < BLK_W; i++) o[6'(BLK_W-ip_src(i))] = b[6'(BLK_W-1-i)];
    return o;
  endfunction

  function automatic logic [SUBKEY_W-1:0] expand(input logic [WORD_W-1:0] r);
    logic [SUBKEY_W-1:0] o;
    int src;
    for (int j = 0; j < N_SBOX; j++) begin
      for (int k = 0; k < SB_IN_W; k++) begin
        src = ((4 * j + k + WORD_W - 1) % WORD_W) + 1;
        o[6'(SUBKEY_W-1-(SB_IN_W*j+k))] = r[5'(WORD_W-src)];
      end
    end
    return o;
  endfunction

  function automatic logic [WORD_W-1:0] shuffle(input logic [WORD_W-1:0] s);
    logic [WORD_W-1:0] o;
    for (int i = 0; i < WORD_W; i++) o[5'(WORD_W-1-i)] = s[5'(WORD_W-SHUF_T[i])];
    return o;
  endfunction

  function automatic logic [SB_OUT_W-1:0] sbox_val(input int box, input logic [SB_IN_W-1:0] x);
    logic [5:0] idx;
    idx = {x[5], x[0], x[4:1]};
    return SBOX_T[3'(box)][8'(252 - 4 * int'(idx)) +: 4];
  endfunction

  function automatic logic [KHALF_W-1:0] rot_l(input logic [KHALF_W-1:0] v, input logic two);
    return two ? {v[KHALF_W-3:0], v[KHALF_W-1:KHALF_W-2]} : {v[KHALF_W-2:0], v[KHALF_W-1]};
  endfunction

  function automatic logic [KHALF_W-1:0] rot_r(input logic [KHALF_W-1:0] v, input logic two);
    return two ? {v[1:0], v[KHALF_W-1:2]} : {v[0], v[KHALF_W-1:1]};
  endfunction

endpackage

// File: rtl/des_sbox_layer.sv
module des_sbox_layer
  import des_pkg::*;
(
  input  logic [SUBKEY_W-1:0] mix_in,
  output logic [WORD_W-1:0]   sub_out
);

  for (genvar g = 0; g < N_SBOX; g++) begin : g_box
    assign sub_out[WORD_W-1-SB_OUT_W*g -: SB_OUT_W] =
      sbox_val(g, mix_in[SUBKEY_W-1-SB_IN_W*g -: SB_IN_W]);
  end

endmodule

// File: rtl/des_key_unit.sv
module des_key_unit
  import des_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                load_en,
  input  logic [BLK_W-1:0]    load_key,
  input  logic                step_en,
  input  logic                step_dec,
  input  logic                step_two,
  output logic [SUBKEY_W-1:0] subkey
);

  logic [KHALF_W-1:0] c_q, d_q;
  logic [KHALF_W-1:0] c_lft, d_lft, c_rgt, d_rgt;
  logic [KSEL_W-1:0]  sel_key;

  assign sel_key = key_select(load_key);

  always_comb begin
    c_lft  = rot_l(c_q, step_two);
    d_lft  = rot_l(d_q, step_two);
    c_rgt  = rot_r(c_q, step_two);
    d_rgt  = rot_r(d_q, step_two);
    // Encrypt rotates before use; decrypt uses the halves as they stand.
    subkey = step_dec ? key_compress({c_q, d_q}) : key_compress({c_lft, d_lft});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_q <= '0;
      d_q <= '0;
    end else if (load_en) begin
      c_q <= sel_key[KSEL_W-1:KHALF_W];
      d_q <= sel_key[KHALF_W-1:0];
    end else if (step_en) begin
      c_q <= step_dec ? c_rgt : c_lft;
      d_q <= step_dec ? d_rgt : d_lft;
    end
  end

  assert_key_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(load_en || step_en) |=> ($stable(c_q) && $stable(d_q)));

  assert_enc_rot_weight_R4: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load_en && !step_dec) |=>
      ($countones(c_q) == $countones($past(c_q)) && $countones(d_q) == $countones($past(d_q))));

  assert_dec_rot_weight_R5: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load_en && step_dec) |=>
      ($countones(c_q) == $countones($past(c_q)) && $countones(d_q) == $countones($past(d_q))));

endmodule

// File: rtl/des_data_unit.sv
module des_data_unit
  import des_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                load_en,
  input  logic [BLK_W-1:0]    load_blk,
  input  logic                step_en,
  input  logic [SUBKEY_W-1:0] subkey,
  output logic [WORD_W-1:0]   l_q,
  output logic [WORD_W-1:0]   r_q
);

  logic [BLK_W-1:0]    perm_blk;
  logic [SUBKEY_W-1:0] mix;
  logic [WORD_W-1:0]   sub_word;
  logic [WORD_W-1:0]   f_word;

  assign perm_blk = ip_perm(load_blk);
  assign mix      = expand(r_q) ^ subkey;
  assign f_word   = shuffle(sub_word);

  des_sbox_layer u_sbox (
    .mix_in  (mix),
    .sub_out (sub_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      l_q <= '0;
      r_q <= '0;
    end else if (load_en) begin
      l_q <= perm_blk[BLK_W-1:WORD_W];
      r_q <= perm_blk[WORD_W-1:0];
    end else if (step_en) begin
      l_q <= r_q;
      r_q <= l_q ^ f_word;
    end
  end

  assert_round_swap_R4: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load_en) |=> (l_q == $past(r_q)));

  assert_data_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(load_en || step_en) |=> ($stable(l_q) && $stable(r_q)));

endmodule

// File: rtl/des_round_copro.sv
module des_round_copro
  import des_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        op_valid,
  input  logic [1:0]  op_code,
  input  logic [1:0]  op_imm,
  input  logic [31:0] op_hi,
  input  logic [31:0] op_lo,
  output logic        res_valid,
  output logic [31:0] res_data
);

  op_e                 op;
  logic                do_ldkey, do_ldblk, do_round, do_read;
  logic [SUBKEY_W-1:0] subkey;
  logic [WORD_W-1:0]   l_q, r_q;
  logic [BLK_W-1:0]    out_blk;

  assign op       = op_e'(op_code);
  assign do_ldkey = op_valid && (op == OP_LDKEY);
  assign do_ldblk = op_valid && (op == OP_LDBLK);
  assign do_round = op_valid && (op == OP_ROUND);
  assign do_read  = op_valid && (op == OP_READ);

  des_key_unit u_key (
    .clk      (clk),
    .rst      (rst),
    .load_en  (do_ldkey),
    .load_key ({op_hi, op_lo}),
    .step_en  (do_round),
    .step_dec (op_imm[0]),
    .step_two (op_imm[1]),
    .subkey   (subkey)
  );

  des_data_unit u_data (
    .clk      (clk),
    .rst      (rst),
    .load_en  (do_ldblk),
    .load_blk ({op_hi, op_lo}),
    .step_en  (do_round),
    .subkey   (subkey),
    .l_q      (l_q),
    .r_q      (r_q)
  );

  // The halves are swapped before the final permutation.
  assign out_blk = fp_perm({r_q, l_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= do_read;
      if (do_read) res_data <= op_imm[0] ? out_blk[WORD_W-1:0] : out_blk[BLK_W-1:WORD_W];
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!res_valid && res_data == '0));

  assert_read_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    do_read |=> res_valid);

  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (rst)
    !do_read |=> (!res_valid && $stable(res_data)));

endmodule

// File: tb/des_round_copro_tb.sv
module des_round_copro_tb;

  localparam logic [1:0] C_LDKEY = 2'd0;
  localparam logic [1:0] C_LDBLK = 2'd1;
  localparam logic [1:0] C_ROUND = 2'd2;
  localparam logic [1:0] C_READ  = 2'd3;
  // One bit per round, round 1 at bit 15; a set bit means a rotation of two.
  localparam logic [15:0] ENC_SH = 16'b0011_1111_0111_1110;
  localparam logic [15:0] DEC_SH = 16'b0111_1110_1111_1100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [1:0]  op_code = 2'd0;
  logic [1:0]  op_imm = 2'd0;
  logic [31:0] op_hi = '0;
  logic [31:0] op_lo = '0;
  logic        res_valid;
  logic [31:0] res_data;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  des_round_copro u_dut (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_imm    (op_imm),
    .op_hi     (op_hi),
    .op_lo     (op_lo),
    .res_valid (res_valid),
    .res_data  (res_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Monitor: pops one expected word per result pulse.
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      exp_t e;
      if (sb_q.size() == 0) begin
        check(1'b0, "R6 unexpected result", res_data, 32'h0);
      end else begin
        e = sb_q.pop_front();
        check(res_data == e.val, e.tag, res_data, e.val);
      end
    end
  end

  task automatic drive(input logic [1:0] code, input logic [1:0] imm, input logic [31:0] hi, input logic [31:0] lo);
    op_valid = 1'b1;
    op_code  = code;
    op_imm   = imm;
    op_hi    = hi;
    op_lo    = lo;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic idle(input int n, input logic [1:0] code);
    op_valid = 1'b0;
    op_code  = code;
    op_imm   = 2'b11;
    op_hi    = 32'hA5A5_5A5A;
    op_lo    = 32'h0F0F_F0F0;
    repeat (n) @(negedge clk);
  endtask

  task automatic load_key(input logic [63:0] k);
    drive(C_LDKEY, 2'b00, k[63:32], k[31:0]);
  endtask

  task automatic load_blk(input logic [63:0] b);
    drive(C_LDBLK, 2'b00, b[63:32], b[31:0]);
  endtask

  task automatic rounds(input bit dec, input bit gaps);
    for (int i = 0; i < 16; i++) begin
      logic two;
      two = dec ? DEC_SH[15-i] : ENC_SH[15-i];
      drive(C_ROUND, {two, dec}, 32'hDEAD_BEEF, 32'h1234_5678);
      if (gaps && (i % 5 == 2)) begin
        idle(1, C_ROUND);
        idle(1, C_LDKEY);
        idle(1, C_LDBLK);
      end
    end
  endtask

  task automatic expect_blk(input logic [63:0] exp, input string tag);
    exp_t e;
    e.val = exp[63:32]; e.tag = tag; sb_q.push_back(e);
    drive(C_READ, 2'b00, 32'h0, 32'h0);
    e.val = exp[31:0];  e.tag = tag; sb_q.push_back(e);
    drive(C_READ, 2'b01, 32'h0, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R6 watchdog expired", 32'h0, 32'h1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state seen at the ports
    check(res_valid == 1'b0, "R1 res_valid after reset", {31'h0, res_valid}, 32'h0);
    check(res_data == 32'h0, "R1 res_data after reset", res_data, 32'h0);
    expect_blk(64'h0, "R1 read after reset");
    rounds(1'b0, 1'b0);
    expect_blk(64'h8CA64DE9C1B123A7, "R1 zero key and block after reset");

    // R2 R3 R4: textbook vector, encrypt; R7 gaps with idle cycles
    load_key(64'h133457799BBCDFF1);
    load_blk(64'h0123456789ABCDEF);
    rounds(1'b0, 1'b1);
    expect_blk(64'h85E813540F0AB405, "R4 encrypt textbook vector");
    // R7: repeated reads do not disturb the state
    expect_blk(64'h85E813540F0AB405, "R7 second read unchanged");
    // R6: result pulse drops, data holds
    idle(1, C_READ);
    check(res_valid == 1'b0, "R6 pulse ends", {31'h0, res_valid}, 32'h0);
    check(res_data == 32'h0F0AB405, "R6 data holds", res_data, 32'h0F0AB405);

    // R5 R8: decrypt right away without reloading the key
    load_blk(64'h85E813540F0AB405);
    rounds(1'b1, 1'b1);
    expect_blk(64'h0123456789ABCDEF, "R5 decrypt textbook vector");
    // R8: encrypt again after decrypting, no key reload
    load_blk(64'h0123456789ABCDEF);
    rounds(1'b0, 1'b0);
    expect_blk(64'h85E813540F0AB405, "R8 key restored after schedules");

    // R2 R4: vector giving all-zero ciphertext
    load_key(64'h0E329232EA6D0D73);
    load_blk(64'h8787878787878787);
    rounds(1'b0, 1'b0);
    expect_blk(64'h0, "R4 encrypt to zero");
    load_blk(64'h0);
    rounds(1'b1, 1'b0);
    expect_blk(64'h8787878787878787, "R5 decrypt from zero");

    // R3: load block leaves key untouched, load key after load block
    load_blk(64'hFFFFFFFFFFFFFFFF);
    load_key(64'hFFFFFFFFFFFFFFFF);
    rounds(1'b0, 1'b0);
    expect_blk(64'h7359B2163E4EDC58, "R3 all ones encrypt");
    load_blk(64'h7359B2163E4EDC58);
    rounds(1'b1, 1'b0);
    expect_blk(64'hFFFFFFFFFFFFFFFF, "R5 all ones decrypt");

    // R2: single-bit ciphertext vector
    load_key(64'h0101010101010101);
    load_blk(64'h95F8A5E5DD31D900);
    rounds(1'b0, 1'b1);
    expect_blk(64'h8000000000000000, "R2 single bit ciphertext");
    load_blk(64'h8000000000000000);
    rounds(1'b1, 1'b0);
    expect_blk(64'h95F8A5E5DD31D900, "R5 single bit decrypt");

    // R1: reset in the middle of a run
    load_key(64'h133457799BBCDFF1);
    load_blk(64'h0123456789ABCDEF);
    for (int i = 0; i < 5; i++) drive(C_ROUND, 2'b00, 32'h0, 32'h0);
    idle(2, C_ROUND);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(res_valid == 1'b0, "R1 res_valid after mid-run reset", {31'h0, res_valid}, 32'h0);
    expect_blk(64'h0, "R1 read after mid-run reset");
    rounds(1'b0, 1'b0);
    expect_blk(64'h8CA64DE9C1B123A7, "R1 state cleared by mid-run reset");

    idle(4, C_ROUND);
    check(sb_q.size() == 0, "R6 all results returned", sb_q.size(), 32'h0);
    summary();
    $finish;
  end

endmodule